// File: doc/BRIEF.md
# Serial-to-Nibble Output Formatter

This block sits behind a burst clock-recovery front end. It receives the retimed bit stream at one bit per clock and presents it downstream either as 4-bit parallel groups or as a pass-through serial stream on the lowest lane. It also produces the output clock, modelled as a pattern of two half-UI samples per UI. That pattern supports full-rate or half-rate (double-edge) clocking and four selectable phase offsets. Separate controls hold the data lanes or the clock at a fixed low idle level.

A burst controller pulses `burst_restart` before each new burst so that group boundaries line up with the start of the burst. The configuration inputs are expected to be static during a burst. The exception is the output mode, which may change at any time: it is applied only where a group completes, so no partial group is ever emitted.

Top module: `nibble_out_formatter`

## Requirements
- R1: After reset, `lane_data`, `nib_valid` and `oclk_pat` are all zero.
- R2: In parallel mode (`cfg_serial`=0), the first four bits after a restart form group 0, and each further four bits form the next group. One clock after the fourth bit of a group, `nib_valid` is 1 for exactly one cycle. The group's earliest bit is on lane 3 and its latest bit is on lane 0. `lane_data` holds that group until the next group completes.
- R3: With `cfg_lane_rev`=1 the lane order is reversed, so the earliest bit of a group is on lane 0 and the latest bit is on lane 3.
- R4: In serial mode (`cfg_serial`=1), `lane_data` equals {3'b000, the bit} one clock after each bit arrives, and `nib_valid` stays 0.
- R5: The bit presented in a cycle where `burst_restart` is 1 is discarded, and the next bit starts a new group. `nib_valid` is 0 in the cycle after a restart.
- R6: A change of `cfg_serial` takes effect only in a cycle where a group completes, or on a restart. From the next output cycle onward, the output follows the new mode. Until then, the old mode continues, including the parallel hold of the last group.
- R7: `oclk_pat[1]` is the clock level in the first half of a UI and `oclk_pat[0]` is the level in the second half. Let u = 0 in the output cycle where a group appears, counting up modulo 8, and let slot s = 2u + h, where h = 0 for the first half and h = 1 for the second. The clock is high when ((s − base − offset) mod L) < L/2. The values of L and base are set by mode:
  - parallel full rate: L = 8, base = 4
  - parallel double-edge (`cfg_par_ddr`=1): L = 16, base = 4
  - serial half rate (default): L = 4, base = 1
  - serial full rate (`cfg_ser_fullrate`=1): L = 2, base = 1
- R8: `cfg_clk_phase` sets the offset in half-UI steps: 00 gives 0, 01 gives +4, 10 gives +1, and 11 gives −3.
- R9: `cfg_data_off`=1 forces `lane_data` to 0 on the next output cycle and leaves `nib_valid` unaffected. `cfg_clk_off`=1 forces `oclk_pat` to 00 on the next output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_bit | input | 1 | Retimed serial data, one bit per clock |
| burst_restart | input | 1 | Starts a new group boundary, discarding this cycle's bit |
| cfg_serial | input | 1 | 1 selects serial pass-through, 0 selects parallel groups |
| cfg_lane_rev | input | 1 | 1 puts the earliest bit on lane 0 |
| cfg_par_ddr | input | 1 | 1 selects the half-rate clock in parallel mode |
| cfg_ser_fullrate | input | 1 | 1 selects the full-rate clock in serial mode |
| cfg_clk_phase | input | 2 | Clock phase offset select |
| cfg_clk_off | input | 1 | Holds the clock pattern at 00 |
| cfg_data_off | input | 1 | Holds the data lanes at 0 |
| lane_data | output | 4 | Output lanes |
| nib_valid | output | 1 | One-cycle strobe when a new group is presented |
| oclk_pat | output | 2 | Output clock samples for the two half-UIs |

## Verification
The main sweep runs a distinct pseudo-random 16-bit stream through every combination of mode, lane order, both clock-rate bits, all four phase codes and both disables. Each stream is long enough to give four complete groups. The expected lanes and clock samples are computed arithmetically from the bit index. This sweep separates the two lane orders and tells each of the sixteen (rate, phase) clock shapes from the others. Directed streams use group contents that cannot be mistaken for a serial bit. One switches the mode in the middle of a group, in both directions, to show that the switch waits for the boundary. Another restarts part-way through a group to show the boundary moving and the discarded bit.

// File: rtl/outfmt_pkg.sv
package outfmt_pkg;

  typedef enum logic [1:0] {
    PH_CENTRE    = 2'b00,
    PH_PLUS_TWO  = 2'b01,
    PH_PLUS_HALF = 2'b10,
    PH_MINUS_1P5 = 2'b11
  } phase_sel_e;

  // Phase offset in half-UI steps, two's complement.
  function automatic logic [7:0] phase_shift_slots(input logic [1:0] sel);
    case (phase_sel_e'(sel))
      PH_PLUS_TWO:  return 8'sd4;
      PH_PLUS_HALF: return 8'sd1;
      PH_MINUS_1P5: return 8'hFD;
      default:      return 8'sd0;
    endcase
  endfunction

endpackage

// File: rtl/outfmt_grouper.sv
module outfmt_grouper #(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_bit,
  input  logic                    restart,
  output logic [$clog2(LANES):0]  grp_cnt,
  output logic                    group_done,
  output logic [LANES-1:0]        nibble
);
  localparam int CNT_W = $clog2(LANES);
  localparam int UI_W  = CNT_W + 1;

  logic [LANES-2:0] shreg_q, shreg_nxt;
  logic [UI_W-1:0]  cnt_q, cnt_nxt;

  // Earliest bit lands in the MSB.
  assign nibble     = {shreg_q, rx_bit};
  assign group_done = !restart && (cnt_q[CNT_W-1:0] == CNT_W'(LANES-1));
  assign grp_cnt    = cnt_q;

  always_comb begin
    if (restart) begin
      cnt_nxt   = '0;
      shreg_nxt = '0;
    end else begin
      cnt_nxt   = cnt_q + UI_W'(1);
      shreg_nxt = nibble[LANES-2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      cnt_q   <= cnt_nxt;
      shreg_q <= shreg_nxt;
    end
  end
endmodule

// File: rtl/outfmt_clkgen.sv
module outfmt_clkgen
  import outfmt_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [$clog2(LANES):0] ui,
  input  logic                   serial,
  input  logic                   par_ddr,
  input  logic                   ser_full,
  input  logic [1:0]             phase,
  output logic [1:0]             pat
);
  localparam int CNT_W  = $clog2(LANES);
  localparam int SLOT_W = CNT_W + 2;
  localparam int IDX_W  = $clog2(SLOT_W);

  logic [7:0]        off8;
  logic [SLOT_W-1:0] base, shift, slot0, slot1, d0, d1;
  logic [IDX_W-1:0]  hbit;

  assign off8  = phase_shift_slots(phase);
  assign base  = serial ? SLOT_W'(1) : SLOT_W'(LANES);
  assign shift = base + off8[SLOT_W-1:0];
  assign slot0 = {ui, 1'b0};
  assign slot1 = {ui, 1'b1};
  assign d0    = slot0 - shift;
  assign d1    = slot1 - shift;

  // Period is 2^(hbit+1) slots; the clock is high in the first half of it.
  always_comb begin
    if (serial) hbit = ser_full ? IDX_W'(0) : IDX_W'(1);
    else        hbit = par_ddr ? IDX_W'(CNT_W + 1) : IDX_W'(CNT_W);
  end

  assign pat = {~d0[hbit], ~d1[hbit]};
endmodule

// File: rtl/nibble_out_formatter.sv
module nibble_out_formatter #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             burst_restart,
  input  logic             cfg_serial,
  input  logic             cfg_lane_rev,
  input  logic             cfg_par_ddr,
  input  logic             cfg_ser_fullrate,
  input  logic [1:0]       cfg_clk_phase,
  input  logic             cfg_clk_off,
  input  logic             cfg_data_off,
  output logic [LANES-1:0] lane_data,
  output logic             nib_valid,
  output logic [1:0]       oclk_pat
);
  localparam int CNT_W = $clog2(LANES);
  localparam int UI_W  = CNT_W + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [UI_W-1:0]  grp_cnt, ui_nxt;
  logic             group_done;
  logic [LANES-1:0] nibble, ordered, data_q, data_nxt;
  logic             mode_q, mode_nxt, load_data;
  logic [1:0]       pat;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  outfmt_grouper #(.LANES(LANES)) u_grp (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rx_bit     (rx_bit),
    .restart    (burst_restart),
    .grp_cnt    (grp_cnt),
    .group_done (group_done),
    .nibble     (nibble)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_rev
    assign ordered[i] = cfg_lane_rev ? nibble[LANES-1-i] : nibble[i];
  end

  // Mode is sampled only at a group boundary or a restart.
  assign mode_nxt  = (group_done || burst_restart) ? cfg_serial : mode_q;
  assign load_data = mode_nxt || group_done;

  always_comb begin
    if (mode_nxt)        data_nxt = {{(LANES-1){1'b0}}, rx_bit};
    else if (group_done) data_nxt = ordered;
    else                 data_nxt = data_q;
  end

  // Position within the two-group clock window, aligned to the output stage.
  assign ui_nxt = burst_restart ? UI_W'(LANES) : grp_cnt + UI_W'(LANES + 1);

  outfmt_clkgen #(.LANES(LANES)) u_clk (
    .ui       (ui_nxt),
    .serial   (mode_nxt),
    .par_ddr  (cfg_par_ddr),
    .ser_full (cfg_ser_fullrate),
    .phase    (cfg_clk_phase),
    .pat      (pat)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mode_q    <= 1'b0;
      data_q    <= '0;
      lane_data <= '0;
      nib_valid <= 1'b0;
      oclk_pat  <= 2'b00;
    end else begin
      mode_q <= mode_nxt;
      if (load_data) data_q <= data_nxt;
      lane_data <= cfg_data_off ? '0 : data_nxt;
      nib_valid <= group_done && !mode_nxt;
      oclk_pat  <= cfg_clk_off ? 2'b00 : pat;
    end
  end
endmodule

// File: rtl/nibble_out_formatter_chk.sv
module nibble_out_formatter_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_restart,
  input logic             cfg_clk_off,
  input logic             cfg_data_off,
  input logic [LANES-1:0] lane_data,
  input logic             nib_valid,
  input logic [1:0]       oclk_pat,
  input logic             mode_q
);
  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    nib_valid |=> !nib_valid);

  a_r4_serial_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (lane_data[LANES-1:1] == '0));

  a_r4_no_valid_serial: assert property (@(posedge clk) disable iff (!rst_n)
    nib_valid |-> !mode_q);

  a_r5_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    burst_restart |=> !nib_valid);

  a_r9_data_off: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_data_off |=> (lane_data == '0));

  a_r9_clk_off: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_off |=> (oclk_pat == 2'b00));
endmodule

bind nibble_out_formatter nibble_out_formatter_chk #(.LANES(LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .burst_restart (burst_restart),
  .cfg_clk_off   (cfg_clk_off),
  .cfg_data_off  (cfg_data_off),
  .lane_data     (lane_data),
  .nib_valid     (nib_valid),
  .oclk_pat      (oclk_pat),
  .mode_q        (mode_q)
);

// File: tb/nibble_out_formatter_tb.sv
module nibble_out_formatter_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, rx_bit, burst_restart;
  logic       cfg_serial, cfg_lane_rev, cfg_par_ddr, cfg_ser_fullrate;
  logic [1:0] cfg_clk_phase;
  logic       cfg_clk_off, cfg_data_off;
  logic [3:0] lane_data;
  logic       nib_valid;
  logic [1:0] oclk_pat;

  int checks = 0;
  int failures = 0;

  nibble_out_formatter u_dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .burst_restart(burst_restart),
    .cfg_serial(cfg_serial), .cfg_lane_rev(cfg_lane_rev), .cfg_par_ddr(cfg_par_ddr),
    .cfg_ser_fullrate(cfg_ser_fullrate), .cfg_clk_phase(cfg_clk_phase),
    .cfg_clk_off(cfg_clk_off), .cfg_data_off(cfg_data_off),
    .lane_data(lane_data), .nib_valid(nib_valid), .oclk_pat(oclk_pat)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_clk(input bit ser, input bit ddr, input bit sf,
                                         input int ph, input int k);
    int L, base, off, u, s, d;
    logic [1:0] r;
    L    = ser ? (sf ? 2 : 4) : (ddr ? 16 : 8);
    base = ser ? 1 : 4;
    off  = (ph == 1) ? 4 : (ph == 2) ? 1 : (ph == 3) ? -3 : 0;
    u    = (k + 5) % 8;
    for (int h = 0; h < 2; h++) begin
      s = 2 * u + h;
      d = (((s - base - off) % L) + L) % L;
      r[1-h] = (d < L / 2);
    end
    return r;
  endfunction

  function automatic logic [3:0] grp(input logic [15:0] b, input int j, input bit rev);
    logic [3:0] n;
    n = {b[4*j], b[4*j+1], b[4*j+2], b[4*j+3]};
    return rev ? {n[0], n[1], n[2], n[3]} : n;
  endfunction

  task automatic step(input logic b);
    rx_bit = b;
    @(posedge clk);
    #1;
  endtask

  task automatic restart();
    burst_restart = 1'b1;
    rx_bit = 1'b1;
    @(posedge clk);
    #1;
    burst_restart = 1'b0;
  endtask

  task automatic run_cfg(input bit ser, input bit rev, input bit ddr, input bit sf,
                         input int ph, input bit coff, input bit doff, input logic [15:0] b);
    logic [3:0] ed;
    cfg_serial = ser; cfg_lane_rev = rev; cfg_par_ddr = ddr; cfg_ser_fullrate = sf;
    cfg_clk_phase = 2'(ph); cfg_clk_off = coff; cfg_data_off = doff;
    restart();
    chk("R5 no valid after restart", int'(nib_valid), 0);
    for (int k = 0; k < 16; k++) begin
      step(b[k]);
      if (ser) begin
        chk("R4 serial valid low", int'(nib_valid), 0);
        ed = {3'b000, b[k]};
      end else begin
        chk("R2 valid strobe", int'(nib_valid), (k % 4 == 3) ? 1 : 0);
        ed = (k >= 3) ? grp(b, (k + 1) / 4 - 1, rev) : 4'h0;
      end
      if (doff) chk("R9 data off", int'(lane_data), 0);
      else if (ser || k >= 3)
        chk(rev ? "R3 lane order" : "R2 R4 lane data", int'(lane_data), int'(ed));
      chk(coff ? "R9 clock off" : "R7 R8 clock pattern", int'(oclk_pat),
          coff ? 0 : int'(exp_clk(ser, ddr, sf, ph, k)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] bits;
    int idx;
    rst_n = 1'b0; rx_bit = 1'b0; burst_restart = 1'b0;
    cfg_serial = 1'b0; cfg_lane_rev = 1'b0; cfg_par_ddr = 1'b0; cfg_ser_fullrate = 1'b0;
    cfg_clk_phase = 2'b00; cfg_clk_off = 1'b0; cfg_data_off = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset lanes", int'(lane_data), 0);
    chk("R1 reset valid", int'(nib_valid), 0);
    chk("R1 reset clock", int'(oclk_pat), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // Sweep of every configuration.
    idx = 0;
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d < 2; d++)
          for (int f = 0; f < 2; f++)
            for (int p = 0; p < 4; p++)
              for (int o = 0; o < 4; o++) begin
                bits = 16'h5A3C ^ 16'(idx * 16'h3B9D);
                run_cfg(s[0], r[0], d[0], f[0], p, o[1], o[0], bits);
                idx++;
              end

    // R6: parallel to serial in the middle of a group.
    cfg_serial = 0; cfg_lane_rev = 0; cfg_par_ddr = 0; cfg_ser_fullrate = 0;
    cfg_clk_phase = 2'b00; cfg_clk_off = 0; cfg_data_off = 0;
    restart();
    step(1); step(0); step(1); step(1);
    chk("R6 first group", int'(lane_data), 4'b1011);
    step(0);
    cfg_serial = 1'b1;
    step(1);
    chk("R6 mode held mid-group", int'(lane_data), 4'b1011);
    step(1);
    chk("R6 mode held mid-group", int'(lane_data), 4'b1011);
    step(1);
    chk("R6 serial from boundary", int'(lane_data), 1);
    chk("R6 no strobe at switch", int'(nib_valid), 0);
    step(0);
    chk("R6 serial after switch", int'(lane_data), 0);
    // R6: serial to parallel in the middle of a group.
    cfg_serial = 1'b0;
    step(1);
    chk("R6 serial held mid-group", int'(lane_data), 1);
    step(1);
    chk("R6 serial held mid-group", int'(lane_data), 1);
    step(0);
    chk("R6 parallel from boundary", int'(lane_data), 4'b0110);
    chk("R6 strobe after switch", int'(nib_valid), 1);

    // R5: restart in the middle of a group moves the boundary.
    restart();
    step(1); step(1);
    restart();
    chk("R5 no valid after restart", int'(nib_valid), 0);
    step(1); step(0); step(0);
    chk("R5 no early strobe", int'(nib_valid), 0);
    step(1);
    chk("R5 new boundary strobe", int'(nib_valid), 1);
    chk("R5 new group data", int'(lane_data), 4'b1001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule